// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block moves the saved processor context between the core and the supervisor stack in memory. When an exception is taken, it moves the stack pointer down by the frame size. It then writes the frame one 16-bit word at a time over a request/acknowledge memory port. When the handler returns, it reads the frame back and hands the restored status word, program counter and stack pointer to the core.

There are two frame sizes. A short frame of four words is used for group 1 and group 2 exceptions. A long frame of 29 words is used for group 0 faults. Every frame carries a format/vector word, and the format code in that word tells the return sequence how far to pop. The internal-state part of the long frame is modelled as a fixed, computed fill pattern. A reset exception writes nothing. Fetching the vector table is the job of another block.

Top module: `exc_frame_seq`

## Requirements
- R1: An entry with group code 0 (reset) makes no memory request, sets sp_o to sp_i, and pulses done_o in the first cycle after the start cycle.
- R2: An entry with group code 2 or 3 writes exactly four words, at ascending addresses from the new stack pointer sp_i-8. The words are SR at SP, PC[31:16] at SP+2, PC[15:0] at SP+4, and the format/vector word at SP+6. sp_o then reads sp_i-8.
- R3: In the format/vector word, bits 15:12 hold the format code and bits 11:0 hold the vector number times 4. Format 0000 is the short frame and format 1000 is the long frame.
- R4: An entry with group code 1 (fault) writes 29 words and sets sp_o to sp_i-58. Its first four words follow the R2 layout, with format 1000. The word at SP+8+2k is 16'hA500+k, for k from 0 to 24.
- R5: Each word transfer keeps mem_req_o, mem_we_o, mem_addr_o and (for writes) mem_wdata_o stable until mem_ack_i. No transfer is repeated or skipped, whatever the acknowledge latency.
- R6: busy_o is high from the cycle after a start until the acknowledge of the last word. done_o is a one-cycle pulse in the cycle after that acknowledge, with busy_o low. sp_o changes only in a done_o cycle.
- R7: A return reads the format/vector word at sp_i+6 first. If the format is 0000, it then reads SR, PC high and PC low. It then updates sr_o and pc_o and sets sp_o to sp_i+8.
- R8: A return that finds format 1000 reads only those same four words, restores sr_o and pc_o, and sets sp_o to sp_i+58.
- R9: A return that finds any other format makes no further reads. It raises fmt_err_o together with done_o, keeps sr_o and pc_o, and sets sp_o to sp_i. fmt_err_o stays high until the next accepted start.
- R10: entry_i and rte_i are ignored while a sequence is running.
- R11: After reset, busy_o, done_o, mem_req_o and fmt_err_o are 0, and sp_o, sr_o and pc_o are 0.
- R12: When entry_i and rte_i are high in the same idle cycle, the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_i | input | 1 | Start exception entry (frame push) |
| rte_i | input | 1 | Start return (frame pop) |
| grp_i | input | 2 | 0 reset, 1 fault (long frame), 2 and 3 short-frame groups |
| sr_i | input | 16 | Status word to save |
| pc_i | input | 32 | Address of next instruction to save |
| vec_i | input | 8 | Vector number |
| sp_i | input | 32 | Current supervisor stack pointer |
| mem_req_o | output | 1 | Word transfer request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Transfer acknowledge |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Frame transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fmt_err_o | output | 1 | Unknown format found on return |
| sp_o | output | 32 | Stack pointer after the last sequence |
| sr_o | output | 16 | Restored status word |
| pc_o | output | 32 | Restored program counter |

## Verification
The assertions watch the handshake on every cycle. They check that a pending request keeps its address, direction and write data until acknowledged, that done_o is a lone pulse with the port idle, that sp_o, sr_o and pc_o move only in a done cycle, and that a format error leaves the restored state untouched. Several behaviours need known stimulus and can only be shown by the bench scenarios: the frame contents and their order, the fill pattern of the long frame, the pointer arithmetic for each frame size, the read sequence on return, and the fact that starts during a transfer are dropped.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
  typedef enum logic [1:0] {
    GRP_RESET = 2'd0,
    GRP_FAULT = 2'd1,
    GRP_ONE   = 2'd2,
    GRP_TWO   = 2'd3
  } exc_grp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP_FMT,
    ST_POP_BODY,
    ST_FIN
  } seq_st_e;

  localparam logic [3:0] FMT_SHORT = 4'h0;
  localparam logic [3:0] FMT_LONG  = 4'h8;
  localparam logic [7:0] FILL_TAG  = 8'hA5;
endpackage

// File: rtl/exc_frame_word.sv
module exc_frame_word
  import exc_frame_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 5,
  parameter int HDR_N = 4
) (
  input  logic [IW-1:0]   idx_i,
  input  logic            long_i,
  input  logic [DW-1:0]   sr_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [7:0]      vec_i,
  output logic [DW-1:0]   word_o
);
  logic [IW-1:0] fill_idx;
  logic [3:0]    fmt;

  assign fill_idx = idx_i - IW'(HDR_N);
  assign fmt      = long_i ? FMT_LONG : FMT_SHORT;

  always_comb begin
    if (idx_i == IW'(0))      word_o = sr_i;
    else if (idx_i == IW'(1)) word_o = pc_i[2*DW-1:DW];
    else if (idx_i == IW'(2)) word_o = pc_i[DW-1:0];
    else if (idx_i == IW'(3)) word_o = DW'({fmt, 2'b00, vec_i, 2'b00});
    else                      word_o = DW'({FILL_TAG, 8'(fill_idx)});
  end
endmodule

// File: rtl/exc_frame_ctrl.sv
module exc_frame_ctrl
  import exc_frame_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SHORT_N = 4,
  parameter int LONG_N = 29,
  parameter int IW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            entry_i,
  input  logic            rte_i,
  input  exc_grp_e        grp_i,
  input  logic [AW-1:0]   sp_i,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            cap_o,
  output logic [IW-1:0]   idx_o,
  output logic            long_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            fmt_err_o,
  output logic [AW-1:0]   sp_o,
  output logic [DW-1:0]   sr_o,
  output logic [2*DW-1:0] pc_o
);
  localparam logic [AW-1:0] SHORT_B = AW'(2 * SHORT_N);
  localparam logic [AW-1:0] LONG_B  = AW'(2 * LONG_N);
  localparam logic [AW-1:0] FMT_OFS = AW'(2 * (SHORT_N - 1));

  seq_st_e        st_q;
  logic [IW-1:0]  idx_q, last_q;
  logic           long_q, err_q;
  logic [AW-1:0]  base_q, sp_q;
  logic [DW-1:0]  sr_stg_q, pc_hi_q, sr_q;
  logic [2*DW-1:0] pc_q;
  logic [3:0]     rd_fmt;
  logic           is_fault;

  assign rd_fmt   = mem_rdata_i[DW-1:DW-4];
  assign is_fault = (grp_i == GRP_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      long_q   <= 1'b0;
      err_q    <= 1'b0;
      base_q   <= '0;
      sp_q     <= '0;
      sr_stg_q <= '0;
      pc_hi_q  <= '0;
      sr_q     <= '0;
      pc_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (entry_i) begin
            err_q  <= 1'b0;
            long_q <= is_fault;
            idx_q  <= '0;
            if (grp_i == GRP_RESET) begin
              sp_q <= sp_i;
              st_q <= ST_FIN;
            end else begin
              base_q <= sp_i - (is_fault ? LONG_B : SHORT_B);
              last_q <= is_fault ? IW'(LONG_N - 1) : IW'(SHORT_N - 1);
              st_q   <= ST_PUSH;
            end
          end else if (rte_i) begin
            err_q  <= 1'b0;
            base_q <= sp_i;
            st_q   <= ST_POP_FMT;
          end
        end
        ST_PUSH: if (mem_ack_i) begin
          if (idx_q == last_q) begin
            sp_q <= base_q;
            st_q <= ST_FIN;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        ST_POP_FMT: if (mem_ack_i) begin
          if (rd_fmt == FMT_SHORT || rd_fmt == FMT_LONG) begin
            long_q <= (rd_fmt == FMT_LONG);
            idx_q  <= '0;
            st_q   <= ST_POP_BODY;
          end else begin
            err_q <= 1'b1;
            sp_q  <= base_q;
            st_q  <= ST_FIN;
          end
        end
        ST_POP_BODY: if (mem_ack_i) begin
          idx_q <= idx_q + IW'(1);
          if (idx_q == IW'(0)) sr_stg_q <= mem_rdata_i;
          else if (idx_q == IW'(1)) pc_hi_q <= mem_rdata_i;
          else begin
            sr_q <= sr_stg_q;
            pc_q <= {pc_hi_q, mem_rdata_i};
            sp_q <= base_q + (long_q ? LONG_B : SHORT_B);
            st_q <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_o      = (st_q == ST_IDLE) && entry_i;
  assign idx_o      = idx_q;
  assign long_o     = long_q;
  assign mem_req_o  = (st_q == ST_PUSH) || (st_q == ST_POP_FMT) || (st_q == ST_POP_BODY);
  assign mem_we_o   = (st_q == ST_PUSH);
  assign mem_addr_o = (st_q == ST_POP_FMT) ? base_q + FMT_OFS
                                           : base_q + (AW'(idx_q) << 1);
  assign busy_o     = mem_req_o;
  assign done_o     = (st_q == ST_FIN);
  assign fmt_err_o  = err_q;
  assign sp_o       = sp_q;
  assign sr_o       = sr_q;
  assign pc_o       = pc_q;
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SHORT_N = 4,
  parameter int LONG_N = 29
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            entry_i,
  input  logic            rte_i,
  input  logic [1:0]      grp_i,
  input  logic [DW-1:0]   sr_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [7:0]      vec_i,
  input  logic [AW-1:0]   sp_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fmt_err_o,
  output logic [AW-1:0]   sp_o,
  output logic [DW-1:0]   sr_o,
  output logic [2*DW-1:0] pc_o
);
  localparam int IW = $clog2(LONG_N + 1);

  logic            cap;
  logic [IW-1:0]   idx;
  logic            long_frm;
  logic [DW-1:0]   sr_c;
  logic [2*DW-1:0] pc_c;
  logic [7:0]      vec_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_c  <= '0;
      pc_c  <= '0;
      vec_c <= '0;
    end else if (cap) begin
      sr_c  <= sr_i;
      pc_c  <= pc_i;
      vec_c <= vec_i;
    end
  end

  exc_frame_ctrl #(
    .AW(AW), .DW(DW), .SHORT_N(SHORT_N), .LONG_N(LONG_N), .IW(IW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entry_i    (entry_i),
    .rte_i      (rte_i),
    .grp_i      (exc_grp_e'(grp_i)),
    .sp_i       (sp_i),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .cap_o      (cap),
    .idx_o      (idx),
    .long_o     (long_frm),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fmt_err_o  (fmt_err_o),
    .sp_o       (sp_o),
    .sr_o       (sr_o),
    .pc_o       (pc_o)
  );

  exc_frame_word #(.DW(DW), .IW(IW), .HDR_N(SHORT_N)) u_word (
    .idx_i (idx),
    .long_i(long_frm),
    .sr_i  (sr_c),
    .pc_i  (pc_c),
    .vec_i (vec_c),
    .word_o(mem_wdata_o)
  );
endmodule

// File: rtl/exc_frame_chk.sv
module exc_frame_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_wdata_o,
  input logic            mem_ack_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            fmt_err_o,
  input logic [AW-1:0]   sp_o,
  input logic [DW-1:0]   sr_o,
  input logic [2*DW-1:0] pc_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R5
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !mem_req_o)); // R6
  AST_SP_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_o) |-> done_o); // R6
  AST_RESTORE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sr_o) || !$stable(pc_o)) |-> (done_o && !fmt_err_o)); // R7
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> !mem_req_o); // R9
  AST_ERR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fmt_err_o) |-> ($stable(sr_o) && $stable(pc_o))); // R9
endmodule

bind exc_frame_seq exc_frame_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fmt_err_o  (fmt_err_o),
  .sp_o       (sp_o),
  .sr_o       (sr_o),
  .pc_o       (pc_o)
);

// File: tb/exc_frame_seq_test.sv
module exc_frame_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry = 1'b0, rte = 1'b0;
  logic [1:0]  grp = 2'd0;
  logic [15:0] sr = '0;
  logic [31:0] pc = '0, sp = '0;
  logic [7:0]  vec = '0;
  logic        req, we, ack = 1'b0, busy, done, ferr;
  logic [31:0] addr, sp_o, pc_o;
  logic [15:0] wdata, rdata = '0, sr_o;

  int n_chk = 0, n_fail = 0;
  int wr_n = 0, rd_n = 0, wcnt = 0, lat = 0, done_n = 0;
  logic [31:0] wr_addr [32];
  logic [15:0] wr_data [32];
  logic [31:0] rd_addr [32];
  logic [15:0] mem [128];

  always #10 clk = ~clk;

  exc_frame_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .entry_i(entry), .rte_i(rte), .grp_i(grp),
    .sr_i(sr), .pc_i(pc), .vec_i(vec), .sp_i(sp),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .fmt_err_o(ferr),
    .sp_o(sp_o), .sr_o(sr_o), .pc_o(pc_o)
  );

  // memory responder with programmable wait cycles
  always @(negedge clk) begin
    if (done) done_n++;
    if (ack) begin
      ack = 1'b0;
    end else if (req && rst_n) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        ack = 1'b1;
        if (we) begin
          mem[addr[7:1]] = wdata;
          if (wr_n < 32) begin wr_addr[wr_n] = addr; wr_data[wr_n] = wdata; end
          wr_n++;
        end else begin
          rdata = mem[addr[7:1]];
          if (rd_n < 32) rd_addr[rd_n] = addr;
          rd_n++;
        end
      end else wcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    wr_n = 0; rd_n = 0; done_n = 0;
  endtask

  task automatic start(input logic e, input logic r);
    @(negedge clk);
    entry = e; rte = r;
    @(negedge clk);
    entry = 1'b0; rte = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset_state();
    chk("R11 busy", 32'(busy), 0);
    chk("R11 done", 32'(done), 0);
    chk("R11 req", 32'(req), 0);
    chk("R11 ferr", 32'(ferr), 0);
    chk("R11 sp", sp_o, 0);
    chk("R11 sr", 32'(sr_o), 0);
    chk("R11 pc", pc_o, 0);
  endtask

  task automatic t_reset_exc();
    int c;
    clr_log();
    grp = 2'd0; sp = 32'h0000_1234;
    start(1'b1, 1'b0);
    chk("R1 done next cycle", 32'(done), 1);
    wait_done(c);
    @(negedge clk);
    chk("R1 writes", 32'(wr_n), 0);
    chk("R1 sp", sp_o, 32'h1234);
    chk("R6 single done", 32'(done_n), 1);
  endtask

  task automatic t_short_entry(input int l);
    int c;
    clr_log(); lat = l;
    grp = 2'd2; sr = 16'h2704; pc = 32'h0001_2346; vec = 8'd5; sp = 32'h0000_1080;
    start(1'b1, 1'b0);
    chk("R6 busy during", 32'(busy), 1);
    wait_done(c);
    chk("R6 busy low at done", 32'(busy), 0);
    @(negedge clk);
    chk("R6 single done", 32'(done_n), 1);
    chk("R2 write count", 32'(wr_n), 4);
    chk("R2 sp", sp_o, 32'h1078);
    for (int k = 0; k < 4; k++) chk("R2 addr", wr_addr[k], 32'h1078 + 32'(2 * k));
    chk("R2 sr word", 32'(wr_data[0]), 32'h2704);
    chk("R2 pc hi", 32'(wr_data[1]), 32'h0001);
    chk("R2 pc lo", 32'(wr_data[2]), 32'h2346);
    chk("R3 fmt vec", 32'(wr_data[3]), 32'h0014);
    chk("R5 no repeat with waits", 32'(wr_n), 4);
  endtask

  task automatic t_long_entry();
    int c;
    clr_log(); lat = 1;
    grp = 2'd1; sr = 16'hA71F; pc = 32'h00C0_FFEE; vec = 8'd3; sp = 32'h0000_10C0;
    start(1'b1, 1'b0);
    wait_done(c);
    @(negedge clk);
    chk("R4 write count", 32'(wr_n), 29);
    chk("R4 sp", sp_o, 32'h1086);
    chk("R4 sr", 32'(wr_data[0]), 32'hA71F);
    chk("R4 pc hi", 32'(wr_data[1]), 32'h00C0);
    chk("R4 pc lo", 32'(wr_data[2]), 32'hFFEE);
    chk("R3 long fmt vec", 32'(wr_data[3]), 32'h800C);
    for (int k = 0; k < 25; k++) begin
      chk("R4 fill addr", wr_addr[4 + k], 32'h108E + 32'(2 * k));
      chk("R4 fill data", 32'(wr_data[4 + k]), 32'hA500 + 32'(k));
    end
  endtask

  task automatic t_rte_short();
    int c;
    clr_log(); lat = 2;
    sp = 32'h0000_1078;
    start(1'b0, 1'b1);
    wait_done(c);
    @(negedge clk);
    chk("R7 reads", 32'(rd_n), 4);
    chk("R7 first read fmt", rd_addr[0], 32'h107E);
    chk("R7 sr", 32'(sr_o), 32'h2704);
    chk("R7 pc", pc_o, 32'h0001_2346);
    chk("R7 sp", sp_o, 32'h1080);
    chk("R7 no err", 32'(ferr), 0);
  endtask

  task automatic t_rte_long();
    int c;
    clr_log(); lat = 0;
    sp = 32'h0000_1086;
    start(1'b0, 1'b1);
    wait_done(c);
    @(negedge clk);
    chk("R8 reads", 32'(rd_n), 4);
    chk("R8 last read", rd_addr[3], 32'h108A);
    chk("R8 sr", 32'(sr_o), 32'hA71F);
    chk("R8 pc", pc_o, 32'h00C0_FFEE);
    chk("R8 sp", sp_o, 32'h10C0);
  endtask

  task automatic t_rte_bad();
    int c;
    clr_log(); lat = 1;
    mem[7'h13] = 16'h3000;  // format word at 0x1026
    sp = 32'h0000_1020;
    start(1'b0, 1'b1);
    wait_done(c);
    chk("R9 err with done", 32'(ferr), 1);
    @(negedge clk);
    chk("R9 reads", 32'(rd_n), 1);
    chk("R9 sr kept", 32'(sr_o), 32'hA71F);
    chk("R9 pc kept", pc_o, 32'h00C0_FFEE);
    chk("R9 sp", sp_o, 32'h1020);
    chk("R9 err held", 32'(ferr), 1);
  endtask

  task automatic t_ignore_busy();
    int c;
    clr_log(); lat = 2;
    grp = 2'd3; sr = 16'h0011; pc = 32'h0000_4000; vec = 8'd32; sp = 32'h0000_1060;
    start(1'b1, 1'b0);
    chk("R9 err cleared on start", 32'(ferr), 0);
    @(negedge clk);
    entry = 1'b1; rte = 1'b1; grp = 2'd1;
    @(negedge clk);
    entry = 1'b0; rte = 1'b0;
    wait_done(c);
    repeat (3) @(negedge clk);
    chk("R10 writes", 32'(wr_n), 4);
    chk("R10 reads", 32'(rd_n), 0);
    chk("R10 done count", 32'(done_n), 1);
    chk("R10 sp", sp_o, 32'h1058);
    chk("R3 vec 32", 32'(wr_data[3]), 32'h0080);
  endtask

  task automatic t_both();
    int c;
    clr_log(); lat = 0;
    grp = 2'd2; sp = 32'h0000_1040;
    start(1'b1, 1'b1);
    wait_done(c);
    @(negedge clk);
    chk("R12 writes", 32'(wr_n), 4);
    chk("R12 reads", 32'(rd_n), 0);
    chk("R12 sp", sp_o, 32'h1038);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_exc();
    t_short_entry(0);
    t_short_entry(2);
    t_long_entry();
    t_rte_short();
    t_rte_long();
    t_rte_bad();
    t_ignore_busy();
    t_both();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule